// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This controller takes a loop trip count N and cuts it into a series of vector strips, none longer than the maximum vector length (MVL, 64 by default). Each strip is presented as a start offset and a length on a valid/ready handshake, so a downstream vector unit can run one vector operation per strip. The odd-sized part, N mod MVL, goes out first at offset 0. Every strip after it is a full MVL strip, and the offset moves forward by the length of the strip just accepted, up to N.

A job starts with a one-cycle start pulse that carries N. A start that arrives while a job is in flight is dropped. Once the final strip has been accepted, the block raises a done flag. That flag stays high until the next job is accepted. When N mod MVL is zero, the empty leading strip is never issued. When N is zero, no strip is issued at all and done follows straight away.

Top module: `strip_seq`

## Requirements
- R1: After reset, strip_valid_o and done_o are both 0.
- R2: When N mod 64 is nonzero, the first strip of a job has offset 0 and length N mod 64. It appears one cycle after the start is accepted.
- R3: Every strip after the first has length 64. Its offset is the previous strip's offset plus the previous strip's length.
- R4: When N is a nonzero multiple of 64, the first strip has offset 0 and length 64.
- R5: A start with N = 0 issues no strip, and done_o is 1 in the cycle after the start.
- R6: While strip_valid_o is 1, strip_len_o is between 1 and 64.
- R7: While strip_valid_o is 1 and strip_ready_i is 0, the next cycle shows the same offset and length with strip_valid_o still 1.
- R8: In the cycle after the handshake of the strip that reaches N, strip_valid_o is 0 and done_o is 1. done_o stays 1 until a new start is accepted, and done_o is never 1 together with strip_valid_o.
- R9: A start that arrives while a job is issuing strips, including in the cycle of its final handshake, is ignored. The running strip sequence is unchanged.
- R10: A start with nonzero N, given while done_o is 1, is accepted. In the next cycle done_o is 0 and the new job's first strip is valid at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new job |
| total_i | input | 16 | Trip count N, sampled with start_i |
| strip_valid_o | output | 1 | A strip is offered |
| strip_ready_i | input | 1 | Downstream accepts the offered strip |
| strip_off_o | output | 16 | Element offset of the offered strip |
| strip_len_o | output | 7 | Vector length of the offered strip (1..64) |
| done_o | output | 1 | Job complete; held until the next accepted start |

## Verification
A new start and the acceptance of the last strip can fall in the same cycle. The bench provokes this by holding start_i high with a fresh N during the final handshake of a 64-element job. The start must be dropped: the next cycle must show done_o high, no valid strip, and no trace of the new N. A start given one cycle later, while done_o is high, must then begin the new job at offset 0 with the new length.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strip_len_gen.sv
// Combinational strip sizing: remainder strip first, full strips afterwards.
module strip_len_gen #(
  parameter int N_W   = 16,
  parameter int MVL   = 64,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic [N_W-1:0]   total_i,
  input  logic [N_W-1:0]   off_i,
  output logic [LEN_W-1:0] len_o,
  output logic [N_W-1:0]   next_off_o,
  output logic             last_o
);
  localparam int          RB       = (MVL > 1) ? $clog2(MVL) : 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MVL);

  logic [LEN_W-1:0] rem;
  logic             first_partial;
  logic [N_W:0]     sum;

  generate
    if ((MVL & (MVL - 1)) == 0) begin : g_pow2
      assign rem = LEN_W'(total_i[RB-1:0]);
    end else begin : g_mod
      assign rem = LEN_W'(total_i % N_W'(MVL));
    end
  endgenerate

  assign first_partial = (off_i == '0) && (rem != '0);

  always_comb begin
    if (first_partial) len_o = rem;
    else               len_o = FULL_LEN;
  end

  assign sum        = {1'b0, off_i} + (N_W + 1)'(len_o);
  assign next_off_o = sum[N_W-1:0];
  assign last_o     = (sum >= {1'b0, total_i});
endmodule

// File: rtl/strip_fsm.sv
// Job state, trip count and running offset registers.
module strip_fsm
  import strip_seq_pkg::*;
#(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N_W-1:0] total_i,
  input  logic           ready_i,
  input  logic           last_i,
  input  logic [N_W-1:0] next_off_i,
  output seq_state_e     state_o,
  output logic [N_W-1:0] total_q_o,
  output logic [N_W-1:0] off_q_o
);
  seq_state_e     st_q, st_d;
  logic [N_W-1:0] tot_q, tot_d;
  logic [N_W-1:0] off_q, off_d;
  logic           accept, advance, tot_en, off_en;

  assign accept  = start_i && (st_q != ST_ISSUE);
  assign advance = (st_q == ST_ISSUE) && ready_i && !last_i;
  assign tot_en  = accept;
  assign off_en  = accept || advance;

  always_comb begin
    st_d  = st_q;
    tot_d = tot_q;
    off_d = off_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          tot_d = total_i;
          off_d = '0;
          st_d  = (total_i == '0) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (ready_i) begin
          if (last_i) st_d  = ST_DONE;
          else        off_d = next_off_i;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (tot_en) tot_q <= tot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign state_o   = st_q;
  assign total_q_o = tot_q;
  assign off_q_o   = off_q;
endmodule

// File: rtl/strip_seq.sv
module strip_seq
  import strip_seq_pkg::*;
#(
  parameter int N_W = 16,
  parameter int MVL = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [N_W-1:0]             total_i,
  output logic                       strip_valid_o,
  input  logic                       strip_ready_i,
  output logic [N_W-1:0]             strip_off_o,
  output logic [$clog2(MVL+1)-1:0]   strip_len_o,
  output logic                       done_o
);
  localparam int LEN_W = $clog2(MVL + 1);

  seq_state_e       state;
  logic [N_W-1:0]   total_q, off_q, next_off;
  logic [LEN_W-1:0] len;
  logic             last;

  strip_fsm #(.N_W(N_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .total_i    (total_i),
    .ready_i    (strip_ready_i),
    .last_i     (last),
    .next_off_i (next_off),
    .state_o    (state),
    .total_q_o  (total_q),
    .off_q_o    (off_q)
  );

  strip_len_gen #(.N_W(N_W), .MVL(MVL), .LEN_W(LEN_W)) i_len (
    .total_i    (total_q),
    .off_i      (off_q),
    .len_o      (len),
    .next_off_o (next_off),
    .last_o     (last)
  );

  assign strip_valid_o = (state == ST_ISSUE);
  assign done_o        = (state == ST_DONE);
  assign strip_off_o   = off_q;
  assign strip_len_o   = len;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int N_W = 16,
  parameter int MVL = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic [N_W-1:0]           total_i,
  input logic                     strip_valid_o,
  input logic                     strip_ready_i,
  input logic [N_W-1:0]           strip_off_o,
  input logic [$clog2(MVL+1)-1:0] strip_len_o,
  input logic                     done_o
);
  p_first_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strip_valid_o) |-> (strip_off_o == '0));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_valid_o && strip_ready_i) |=>
      (!strip_valid_o ||
       ({1'b0, strip_off_o} == ({1'b0, $past(strip_off_o)} + (N_W + 1)'($past(strip_len_o))))));

  p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strip_valid_o |-> (strip_len_o != '0 && int'(strip_len_o) <= MVL));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_valid_o && !strip_ready_i) |=>
      (strip_valid_o && $stable(strip_off_o) && $stable(strip_len_o)));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !strip_valid_o);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && total_i != '0) |=>
      (strip_valid_o && !done_o && strip_off_o == '0));
endmodule

bind strip_seq strip_seq_chk #(.N_W(N_W), .MVL(MVL)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .total_i       (total_i),
  .strip_valid_o (strip_valid_o),
  .strip_ready_i (strip_ready_i),
  .strip_off_o   (strip_off_o),
  .strip_len_o   (strip_len_o),
  .done_o        (done_o)
);

// File: tb/test_strip_seq.sv
`timescale 1ns/1ps
module test_strip_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] total_i;
  logic        strip_valid_o;
  logic        strip_ready_i;
  logic [15:0] strip_off_o;
  logic [6:0]  strip_len_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  strip_seq i_strip_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_i(total_i),
    .strip_valid_o(strip_valid_o), .strip_ready_i(strip_ready_i),
    .strip_off_o(strip_off_o), .strip_len_o(strip_len_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one job; stall>0 drops ready every stall-th cycle; poke>=0 pulses a
  // stray start at that cycle index (R9).
  task automatic run_job(input int n, input int stall, input int poke, input string req);
    int exp_off = 0;
    int exp_len = (n % 64 != 0) ? n % 64 : 64;
    int cyc = 0;
    bit held = 0;
    int h_off = 0, h_len = 0;
    bit rdy;
    start_i = 1'b1; total_i = 16'(n);
    step();
    start_i = 1'b0;
    while (exp_off < n && cyc < 8000) begin
      chk(strip_valid_o == 1'b1, req, "valid", int'(strip_valid_o), 1);
      chk(int'(strip_off_o) == exp_off, (exp_off == 0) ? "R2" : "R3", "offset", int'(strip_off_o), exp_off);
      chk(int'(strip_len_o) == exp_len, (exp_off == 0) ? req : "R3", "length", int'(strip_len_o), exp_len);
      if (held) chk(int'(strip_off_o) == h_off && int'(strip_len_o) == h_len, "R7", "held strip offset", int'(strip_off_o), h_off);
      rdy = (stall == 0) || (cyc % stall != 0);
      strip_ready_i = rdy;
      if (cyc == poke) begin start_i = 1'b1; total_i = 16'd3; end
      held = !rdy; h_off = int'(strip_off_o); h_len = int'(strip_len_o);
      step();
      start_i = 1'b0;
      if (rdy) begin exp_off += exp_len; exp_len = 64; end
      cyc++;
    end
    strip_ready_i = 1'b0;
    chk(strip_valid_o == 1'b0, "R8", "valid after last", int'(strip_valid_o), 0);
    chk(done_o == 1'b1, "R8", "done after last", int'(done_o), 1);
  endtask

  task automatic t_reset();
    chk(strip_valid_o == 1'b0, "R1", "valid at reset", int'(strip_valid_o), 0);
    chk(done_o == 1'b0, "R1", "done at reset", int'(done_o), 0);
  endtask

  task automatic t_zero();
    start_i = 1'b1; total_i = 16'd0;
    step();
    start_i = 1'b0;
    chk(done_o == 1'b1, "R5", "done for N=0", int'(done_o), 1);
    chk(strip_valid_o == 1'b0, "R5", "no strip for N=0", int'(strip_valid_o), 0);
    step();
    chk(strip_valid_o == 1'b0 && done_o == 1'b1, "R5", "still idle-done", int'(done_o), 1);
  endtask

  task automatic t_coincide();
    start_i = 1'b1; total_i = 16'd64;
    step();
    start_i = 1'b0;
    chk(strip_valid_o && strip_off_o == 16'd0 && strip_len_o == 7'd64, "R4", "single full strip", int'(strip_len_o), 64);
    chk(done_o == 1'b0, "R10", "done cleared by start", int'(done_o), 0);
    strip_ready_i = 1'b1; start_i = 1'b1; total_i = 16'd10;
    step();
    start_i = 1'b0; strip_ready_i = 1'b0;
    chk(strip_valid_o == 1'b0, "R9", "start at final handshake ignored", int'(strip_valid_o), 0);
    chk(done_o == 1'b1, "R8", "done after final handshake", int'(done_o), 1);
    step();
    chk(done_o == 1'b1 && strip_valid_o == 1'b0, "R8", "done held", int'(done_o), 1);
    start_i = 1'b1; total_i = 16'd10;
    step();
    start_i = 1'b0;
    chk(done_o == 1'b0, "R10", "done cleared on restart", int'(done_o), 0);
    chk(strip_valid_o && strip_off_o == 16'd0 && strip_len_o == 7'd10, "R10", "restart strip length", int'(strip_len_o), 10);
    strip_ready_i = 1'b1;
    step();
    strip_ready_i = 1'b0;
    chk(done_o == 1'b1, "R8", "done after restart job", int'(done_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; total_i = '0; strip_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    run_job(150, 0, -1, "R2");
    run_job(128, 0, -1, "R4");
    run_job(5, 0, -1, "R2");
    run_job(200, 3, -1, "R7");
    run_job(70, 0, 1, "R9");
    run_job(65535, 0, -1, "R6");
    t_coincide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule